// File: doc/BRIEF.md
# Dual-Read Multiply-Accumulate Slice with Pointer Update

This block is the execute slice of a 16-bit signal-processing core for a multiply-accumulate instruction that carries two parallel memory moves. In one cycle it multiplies the two operand registers X0 and Y0 as signed fractions and adds the doubled product into a 36-bit accumulator. The accumulator has 4 guard bits, a high word and a low word. In the same cycle it reads two words from a dual-port data memory over two separate address/data pairs. It loads those words into the operand registers and post-modifies the two address pointers.

The memory is read asynchronously. The slice drives both addresses continuously from its pointers and samples both data inputs at the clock edge that ends the instruction. The multiplier always uses the operand values held before that edge, so a stream of back-to-back instructions forms a software pipeline: each multiply consumes the words fetched by the instruction before it.

The move fields take effect only alongside an arithmetic operation. Separate load strobes preset the two pointers and the signed offset register. The slice is single-cycle and has no state sequencing of its own. Every update is decided by the control inputs of the current cycle.

Top module: `mac_dual_read_slice`

## Requirements
- R1: A synchronous reset, sampled high at a clock edge, clears the accumulator, X0, Y0, pointer A, pointer B and the offset register to zero at that edge.
- R2: When `op_valid` is high at a clock edge, the accumulator becomes its old value plus the signed 16x16 product of the old X0 and old Y0. The product is sign-extended to 36 bits and shifted left by one, and the sum wraps modulo 2^36.
- R3: When `op_valid` and `move_en` are both high at a clock edge, Y0 takes `rd_a_data` and X0 takes `rd_b_data`. The new values appear on `y0_out` and `x0_out` after that edge.
- R4: On such a move edge, pointer A becomes pointer A plus the offset register, with the offset read as a signed 16-bit value. Pointer B becomes pointer B minus one. Both wrap modulo 2^16.
- R5: When `move_en` is high and `op_valid` is low, X0, Y0, both pointers and the accumulator keep their values, and both read strobes stay low.
- R6: When `op_valid` is high and `move_en` is low, the accumulator updates as in R2, while X0, Y0 and both pointers keep their values.
- R7: `rd_a_addr` always equals pointer A and `rd_b_addr` always equals pointer B. `rd_a_en` and `rd_b_en` are each high exactly when `op_valid` and `move_en` are both high.
- R8: `ld_ptr_a`, `ld_ptr_b` and `ld_offset` each write `ld_value` into their register at the clock edge. A load takes priority over a post-update of the same pointer in that cycle.
- R9: Multiplying -1.0 (0x8000) by -1.0 adds +1.0, which is 0x0_8000_0000, to the accumulator. This shows up as bit 31 set with the guard bits zero, not as a negative value.
- R10: When `op_valid` is low, the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Arithmetic multiply-accumulate issued this cycle |
| move_en | input | 1 | Parallel-move fields enabled |
| ld_ptr_a | input | 1 | Preset pointer A from `ld_value` |
| ld_ptr_b | input | 1 | Preset pointer B from `ld_value` |
| ld_offset | input | 1 | Preset the signed offset register from `ld_value` |
| ld_value | input | 16 | Preset value |
| rd_a_addr | output | 16 | Primary read address (pointer A) |
| rd_a_en | output | 1 | Primary read strobe |
| rd_a_data | input | 16 | Primary read data, loads Y0 |
| rd_b_addr | output | 16 | Secondary read address (pointer B) |
| rd_b_en | output | 1 | Secondary read strobe |
| rd_b_data | input | 16 | Secondary read data, loads X0 |
| acc_out | output | 36 | Accumulator |
| x0_out | output | 16 | Operand register X0 |
| y0_out | output | 16 | Operand register Y0 |
| ptr_a_out | output | 16 | Pointer A |
| ptr_b_out | output | 16 | Pointer B |
| offset_out | output | 16 | Offset register |

## Verification
A wrong pointer update shows on the read address outputs right after the faulty edge. It then corrupts the operand loaded one move later, and the accumulator one further multiply after that. An operand register updated too early, for example with the multiplier fed by the new value instead of the old, leaves the operands correct but skews the accumulator on the very next edge. For that reason the bench compares the accumulator after every cycle, not only at the end of a run. Enable and gating faults on the move fields show at once as a moved pointer or a read strobe that should have stayed low, and the bench checks these under randomly mixed control inputs.

// File: rtl/mdr_pkg.sv
package mdr_pkg;

    // Post-update rule of one address pointer
    typedef enum logic {
        PTR_ADD_OFFSET = 1'b0,
        PTR_DEC_ONE    = 1'b1
    } ptr_mode_e;

    // Decoded slice controls for one cycle
    typedef struct packed {
        logic alu_go;
        logic move_go;
    } slice_ctl_t;

endpackage

// File: rtl/mdr_agu.sv
module mdr_agu
    import mdr_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter ptr_mode_e   MODE   = PTR_ADD_OFFSET
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  logic [ADDR_W-1:0] offset,
    output logic [ADDR_W-1:0] ptr
);

    logic [ADDR_W-1:0] ptr_next;

    generate
        if (MODE == PTR_ADD_OFFSET) begin : g_offset
            // two's-complement add covers a signed offset with wraparound
            always_comb ptr_next = ptr + offset;
        end else begin : g_dec
            logic unused_offset;
            always_comb unused_offset = ^offset;
            always_comb ptr_next = ptr - ADDR_W'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step) begin
            ptr <= ptr_next;
        end
    end

endmodule

// File: rtl/mdr_operands.sv
module mdr_operands #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [DATA_W-1:0] prim_data,
    input  logic [DATA_W-1:0] sec_data,
    output logic [DATA_W-1:0] x0,
    output logic [DATA_W-1:0] y0
);

    always_ff @(posedge clk) begin
        if (rst) begin
            x0 <= '0;
            y0 <= '0;
        end else if (load_en) begin
            y0 <= prim_data;
            x0 <= sec_data;
        end
    end

endmodule

// File: rtl/mdr_mac.sv
module mdr_mac #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned EXT_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          en,
    input  logic [DATA_W-1:0]             opx,
    input  logic [DATA_W-1:0]             opy,
    output logic [2*DATA_W+EXT_W-1:0]     acc
);

    localparam int unsigned PROD_W = 2 * DATA_W;
    localparam int unsigned ACC_W  = PROD_W + EXT_W;

    logic signed [PROD_W-1:0] prod;
    logic        [ACC_W-1:0]  prod_ext;
    logic        [ACC_W-1:0]  addend;

    always_comb begin
        prod     = $signed(opx) * $signed(opy);
        prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
        // fractional alignment: drop the duplicated sign bit
        addend   = prod_ext << 1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + addend;
        end
    end

endmodule

// File: rtl/mac_dual_read_slice.sv
module mac_dual_read_slice
    import mdr_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned EXT_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          op_valid,
    input  logic                          move_en,
    input  logic                          ld_ptr_a,
    input  logic                          ld_ptr_b,
    input  logic                          ld_offset,
    input  logic [ADDR_W-1:0]             ld_value,
    output logic [ADDR_W-1:0]             rd_a_addr,
    output logic                          rd_a_en,
    input  logic [DATA_W-1:0]             rd_a_data,
    output logic [ADDR_W-1:0]             rd_b_addr,
    output logic                          rd_b_en,
    input  logic [DATA_W-1:0]             rd_b_data,
    output logic [2*DATA_W+EXT_W-1:0]     acc_out,
    output logic [DATA_W-1:0]             x0_out,
    output logic [DATA_W-1:0]             y0_out,
    output logic [ADDR_W-1:0]             ptr_a_out,
    output logic [ADDR_W-1:0]             ptr_b_out,
    output logic [ADDR_W-1:0]             offset_out
);

    slice_ctl_t        ctl;
    logic [ADDR_W-1:0] offset_q;

    // moves are legal only alongside an arithmetic operation
    always_comb begin
        ctl.alu_go  = op_valid;
        ctl.move_go = op_valid & move_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            offset_q <= '0;
        end else if (ld_offset) begin
            offset_q <= ld_value;
        end
    end

    mdr_agu #(.ADDR_W(ADDR_W), .MODE(PTR_ADD_OFFSET)) u_agu_a (
        .clk      (clk),
        .rst      (rst),
        .load     (ld_ptr_a),
        .load_val (ld_value),
        .step     (ctl.move_go),
        .offset   (offset_q),
        .ptr      (ptr_a_out)
    );

    mdr_agu #(.ADDR_W(ADDR_W), .MODE(PTR_DEC_ONE)) u_agu_b (
        .clk      (clk),
        .rst      (rst),
        .load     (ld_ptr_b),
        .load_val (ld_value),
        .step     (ctl.move_go),
        .offset   (offset_q),
        .ptr      (ptr_b_out)
    );

    mdr_operands #(.DATA_W(DATA_W)) u_opnd (
        .clk       (clk),
        .rst       (rst),
        .load_en   (ctl.move_go),
        .prim_data (rd_a_data),
        .sec_data  (rd_b_data),
        .x0        (x0_out),
        .y0        (y0_out)
    );

    mdr_mac #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_mac (
        .clk (clk),
        .rst (rst),
        .en  (ctl.alu_go),
        .opx (x0_out),
        .opy (y0_out),
        .acc (acc_out)
    );

    always_comb begin
        rd_a_addr  = ptr_a_out;
        rd_b_addr  = ptr_b_out;
        rd_a_en    = ctl.move_go;
        rd_b_en    = ctl.move_go;
        offset_out = offset_q;
    end

endmodule

// File: rtl/mdr_checker.sv
module mdr_checker #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned EXT_W  = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      op_valid,
    input logic                      move_en,
    input logic                      ld_ptr_a,
    input logic                      ld_ptr_b,
    input logic [ADDR_W-1:0]         rd_a_addr,
    input logic                      rd_a_en,
    input logic [DATA_W-1:0]         rd_a_data,
    input logic [ADDR_W-1:0]         rd_b_addr,
    input logic                      rd_b_en,
    input logic [DATA_W-1:0]         rd_b_data,
    input logic [2*DATA_W+EXT_W-1:0] acc_out,
    input logic [DATA_W-1:0]         x0_out,
    input logic [DATA_W-1:0]         y0_out,
    input logic [ADDR_W-1:0]         ptr_a_out,
    input logic [ADDR_W-1:0]         ptr_b_out,
    input logic [ADDR_W-1:0]         offset_out
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (acc_out == '0 && x0_out == '0 && y0_out == '0 &&
                 ptr_a_out == '0 && ptr_b_out == '0 && offset_out == '0));

    a_r3_operand_load: assert property (@(posedge clk) disable iff (rst)
        (op_valid && move_en) |=> (y0_out == $past(rd_a_data) && x0_out == $past(rd_b_data)));

    a_r4_ptr_a_step: assert property (@(posedge clk) disable iff (rst)
        (op_valid && move_en && !ld_ptr_a) |=> (ptr_a_out == $past(ptr_a_out) + $past(offset_out)));

    a_r4_ptr_b_step: assert property (@(posedge clk) disable iff (rst)
        (op_valid && move_en && !ld_ptr_b) |=> (ptr_b_out == $past(ptr_b_out) - ADDR_W'(1)));

    a_r5_no_move_alone: assert property (@(posedge clk) disable iff (rst)
        (!(op_valid && move_en) && !ld_ptr_a && !ld_ptr_b) |=>
            ($stable(x0_out) && $stable(y0_out) && $stable(ptr_a_out) && $stable(ptr_b_out)));

    a_r7_addr_follow: assert property (@(posedge clk) disable iff (rst)
        (rd_a_addr == ptr_a_out && rd_b_addr == ptr_b_out));

    a_r7_strobe: assert property (@(posedge clk) disable iff (rst)
        (rd_a_en == (op_valid && move_en) && rd_b_en == rd_a_en));

    a_r10_acc_hold: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(acc_out));

endmodule

bind mac_dual_read_slice mdr_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EXT_W(EXT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .move_en    (move_en),
    .ld_ptr_a   (ld_ptr_a),
    .ld_ptr_b   (ld_ptr_b),
    .rd_a_addr  (rd_a_addr),
    .rd_a_en    (rd_a_en),
    .rd_a_data  (rd_a_data),
    .rd_b_addr  (rd_b_addr),
    .rd_b_en    (rd_b_en),
    .rd_b_data  (rd_b_data),
    .acc_out    (acc_out),
    .x0_out     (x0_out),
    .y0_out     (y0_out),
    .ptr_a_out  (ptr_a_out),
    .ptr_b_out  (ptr_b_out),
    .offset_out (offset_out)
);

// File: tb/sim_mac_dual_read_slice.sv
module sim_mac_dual_read_slice;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, move_en, ld_ptr_a, ld_ptr_b, ld_offset;
    logic [15:0] ld_value;
    logic [15:0] rd_a_addr, rd_b_addr, rd_a_data, rd_b_data;
    logic        rd_a_en, rd_b_en;
    logic [35:0] acc_out;
    logic [15:0] x0_out, y0_out, ptr_a_out, ptr_b_out, offset_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // expected state
    logic [35:0] m_acc;
    logic [15:0] m_x0, m_y0, m_pa, m_pb, m_off;

    always #10 clk = ~clk;

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        if (a == 16'h0100) return 16'h8000;
        return (a * 16'h9E37) ^ 16'h5A5A;
    endfunction

    always_comb rd_a_data = mem_word(rd_a_addr);
    always_comb rd_b_data = mem_word(rd_b_addr);

    function automatic logic [35:0] mac_ref(input logic [35:0] acc,
                                            input logic [15:0] x,
                                            input logic [15:0] y);
        logic signed [35:0] p;
        p = 36'(signed'(x)) * 36'(signed'(y));
        return acc + (p * 36'sd2);
    endfunction

    mac_dual_read_slice u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .move_en(move_en),
        .ld_ptr_a(ld_ptr_a), .ld_ptr_b(ld_ptr_b), .ld_offset(ld_offset),
        .ld_value(ld_value),
        .rd_a_addr(rd_a_addr), .rd_a_en(rd_a_en), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_en(rd_b_en), .rd_b_data(rd_b_data),
        .acc_out(acc_out), .x0_out(x0_out), .y0_out(y0_out),
        .ptr_a_out(ptr_a_out), .ptr_b_out(ptr_b_out), .offset_out(offset_out)
    );

    task automatic chk(input string tag, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check strobes, clock, check state
    task automatic step(input logic ov, input logic me, input logic la,
                        input logic lb, input logic lo, input logic [15:0] v,
                        input string tag);
        logic [35:0] n_acc;
        logic [15:0] n_x0, n_y0, n_pa, n_pb, n_off;
        @(negedge clk);
        op_valid = ov; move_en = me; ld_ptr_a = la; ld_ptr_b = lb;
        ld_offset = lo; ld_value = v;
        #1;
        chk("R7", "rd_a_en", 36'(rd_a_en), 36'(ov & me));
        chk("R7", "rd_b_en", 36'(rd_b_en), 36'(ov & me));
        chk("R7", "rd_a_addr", 36'(rd_a_addr), 36'(m_pa));
        chk("R7", "rd_b_addr", 36'(rd_b_addr), 36'(m_pb));
        n_acc = ov ? mac_ref(m_acc, m_x0, m_y0) : m_acc;
        n_x0 = m_x0; n_y0 = m_y0; n_pa = m_pa; n_pb = m_pb; n_off = m_off;
        if (ov && me) begin
            n_y0 = mem_word(m_pa);
            n_x0 = mem_word(m_pb);
            n_pa = m_pa + m_off;
            n_pb = m_pb - 16'd1;
        end
        if (la) n_pa = v;
        if (lb) n_pb = v;
        if (lo) n_off = v;
        @(posedge clk);
        #1;
        m_acc = n_acc; m_x0 = n_x0; m_y0 = n_y0;
        m_pa = n_pa; m_pb = n_pb; m_off = n_off;
        chk(tag, "acc", acc_out, m_acc);
        chk(tag, "x0", 36'(x0_out), 36'(m_x0));
        chk(tag, "y0", 36'(y0_out), 36'(m_y0));
        chk(tag, "ptr_a", 36'(ptr_a_out), 36'(m_pa));
        chk(tag, "ptr_b", 36'(ptr_b_out), 36'(m_pb));
        chk(tag, "offset", 36'(offset_out), 36'(m_off));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] acc_before;
        void'($urandom(32'd12345));
        rst = 1'b1; op_valid = 0; move_en = 0; ld_ptr_a = 0; ld_ptr_b = 0;
        ld_offset = 0; ld_value = 16'h1234;
        repeat (3) @(posedge clk);
        #1;
        m_acc = '0; m_x0 = '0; m_y0 = '0; m_pa = '0; m_pb = '0; m_off = '0;
        chk("R1", "reset acc", acc_out, 36'h0);
        chk("R1", "reset regs", {x0_out, y0_out, ptr_a_out}, {16'h0, 16'h0, 16'h0});
        chk("R1", "reset ptrs", {ptr_b_out, offset_out}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R8: presets
        step(0, 0, 1, 0, 0, 16'h0100, "R8");
        step(0, 0, 0, 1, 0, 16'h0100, "R8");
        step(0, 0, 0, 0, 1, 16'hFFFD, "R8");
        // R3: load -1.0 into both operands, multiplier still sees zeros
        step(1, 1, 0, 0, 0, 16'h0, "R3");
        chk("R3", "x0 is -1.0", 36'(x0_out), 36'h8000);
        chk("R2", "old operands used", acc_out, 36'h0);
        // R9: -1.0 * -1.0 -> +1.0
        step(1, 0, 0, 0, 0, 16'h0, "R9");
        chk("R9", "plus one", acc_out, 36'h0_8000_0000);
        // R6: move fields off leaves operands and pointers alone
        step(1, 0, 0, 0, 0, 16'h0, "R6");
        // R5: moves without an ALU op are ignored
        step(0, 1, 0, 0, 0, 16'h0, "R5");
        chk("R5", "ptr_a kept", 36'(ptr_a_out), 36'h00FD);
        // R10: idle hold
        step(0, 0, 0, 0, 0, 16'h0, "R10");
        // R4: wraparound of pointer B below zero, offset negative wraps A
        step(0, 0, 1, 1, 0, 16'h0001, "R8");
        step(1, 1, 0, 0, 0, 16'h0, "R4");
        step(1, 1, 0, 0, 0, 16'h0, "R4");
        chk("R4", "ptr_b wrap", 36'(ptr_b_out), 36'hFFFF);
        chk("R4", "ptr_a wrap", 36'(ptr_a_out), 36'hFFFB);
        // R8: load beats post-update in the same cycle
        step(1, 1, 1, 0, 0, 16'h4444, "R8");
        chk("R8", "load priority", 36'(ptr_a_out), 36'h4444);
        acc_before = acc_out[15:0];
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            string t;
            r = $urandom;
            t = (r[0] & r[1]) ? "R3" : (r[0] ? "R6" : (r[1] ? "R5" : "R10"));
            step(r[0], r[1], r[4:2] == 3'd0, r[7:5] == 3'd0, r[10:8] == 3'd0,
                 r[31:16], t);
        end
        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        m_acc = '0; m_x0 = '0; m_y0 = '0; m_pa = '0; m_pb = '0; m_off = '0;
        chk("R1", "mid reset acc", acc_out, 36'h0);
        chk("R1", "mid reset ptrs", {ptr_a_out, ptr_b_out}, 32'h0);
        if (acc_before == 16'hxxxx) n_tests++;
        finish_run();
    end

endmodule